// File: doc/BRIEF.md
# Trapezoid Staircase Waveform Sequencer

This block produces a repeating trapezoidal stream of sample codes for a fast digital-to-analog converter whose output feeds an external smoothing filter and a comparator. Each period moves through four segments: the output sits at a high code, steps down to a low code as a short staircase, sits at the low code, and then steps back up. The two plateau durations are programmed independently in clock cycles. Each transition is a staircase of 16 equal steps whose final step lands exactly on the target level.

All new settings (both levels and both durations) are adopted together on the cycle the high plateau begins, so every period runs with one consistent set of values. Pulling `enable` low parks the sequencer in the low segment. While parked, the output follows the low-level input and the settings are tracked continuously. When `enable` returns, the low plateau finishes and the first rising staircase is built from the tracked settings. A segment code tells downstream logic which part of the period is on the output.

Top module: `trapezoid_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `segment` = 2 (low) and `dacCode` = 0. The segment encoding is 0 = high plateau, 1 = falling edge, 2 = low plateau, 3 = rising edge.
- R2: While enabled, the segments follow the order 0, 1, 2, 3, 0 and so on. Each edge segment lasts exactly 16 cycles, each plateau lasts its programmed length, and the period is Lh + Ll + 32 cycles.
- R3: A programmed plateau length of zero behaves exactly like a length of one cycle.
- R4: The step size is floor((high − low) / 16). On cycle k (1 to 15) of an edge, the output is the start level ± k·step. On cycle 16, the output equals the target level exactly.
- R5: Throughout a plateau, `dacCode` is held constant at that plateau's level.
- R6: The levels and lengths are sampled only on the cycle the high plateau begins. Input changes made at any other time do not affect the output until the next high plateau.
- R7: When `enable` is low at a clock edge, the next outputs are `segment` = 2 and `dacCode` equal to the `lowLevel` value present at that edge. All settings are re-sampled on every such cycle.
- R8: When `enable` rises while parked, the parked cycle counts as the first low-plateau cycle. A further max(Ll,1) − 1 low cycles follow, and then the rising edge, built from the parked settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run the sequencer; low parks it in the low segment |
| highLevel | input | CODE_W | Code of the high plateau |
| lowLevel | input | CODE_W | Code of the low plateau |
| highLen | input | LEN_W | High plateau length in cycles (0 acts as 1) |
| lowLen | input | LEN_W | Low plateau length in cycles (0 acts as 1) |
| dacCode | output | CODE_W | Sample code to the converter |
| segment | output | 2 | Active segment: 0 high, 1 fall, 2 low, 3 rise |

## Verification
The bench targets the following cases and the failure each would expose:
- **Level spans not divisible by 16.** A design that accumulates steps without snapping would end each edge short of the target.
- **Zero and unit plateau lengths.** An off-by-one in the length compare either drops a plateau cycle or wraps the counter into a very long plateau.
- **Settings changed mid-period.** A design that samples the inputs continuously would bend the rising edge or shorten the current high plateau. The bench therefore changes the inputs during a rising edge and again during a falling edge, and checks that the old values hold until the next high plateau starts.
- **Disabling in the middle of an edge, and re-enabling from park.** These catch a sequencer that resumes mid-staircase, or one that skips the remainder of the low plateau.

// File: rtl/trap_pkg.sv
package trap_pkg;

  typedef enum logic [1:0] {
    SEG_HIGH = 2'd0,
    SEG_FALL = 2'd1,
    SEG_LOW  = 2'd2,
    SEG_RISE = 2'd3
  } segment_e;

  // strobes from control to datapath, valid for the coming clock edge
  typedef struct packed {
    logic idle;      // parked: follow the low level, resample settings
    logic capture;   // high plateau begins: take new settings
    logic stepDown;  // move one step toward the low level
    logic stepUp;    // move one step toward the high level
    logic lastStep;  // this step must land exactly on the target
  } ctrl_strobes_t;

endpackage

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int EDGE_STEPS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [LEN_W-1:0] highLen,
  input  logic [LEN_W-1:0] lowLen,
  output ctrl_strobes_t    strobes,
  output segment_e         segState
);

  localparam int EDGE_W = $clog2(EDGE_STEPS) + 1;
  localparam int CNT_W  = (LEN_W > EDGE_W) ? LEN_W : EDGE_W;

  segment_e         segQ, segD;
  logic [CNT_W-1:0] cntQ, cntD;
  logic [LEN_W-1:0] hiLenQ, loLenQ;
  logic [LEN_W-1:0] hiLast, loLast;
  logic             edgeLast, edgePenult;

  // zero length behaves as a single cycle
  assign hiLast     = (hiLenQ == '0) ? '0 : hiLenQ - 1'b1;
  assign loLast     = (loLenQ == '0) ? '0 : loLenQ - 1'b1;
  assign edgeLast   = (cntQ == CNT_W'(EDGE_STEPS - 1));
  assign edgePenult = (cntQ == CNT_W'(EDGE_STEPS - 2));

  always_comb begin
    segD    = segQ;
    cntD    = cntQ + 1'b1;
    strobes = '0;
    if (!enable) begin
      segD         = SEG_LOW;
      cntD         = '0;
      strobes.idle = 1'b1;
    end else begin
      case (segQ)
        SEG_HIGH: begin
          if (cntQ == CNT_W'(hiLast)) begin
            segD             = SEG_FALL;
            cntD             = '0;
            strobes.stepDown = 1'b1;
          end
        end
        SEG_FALL: begin
          if (edgeLast) begin
            segD = SEG_LOW;
            cntD = '0;
          end else begin
            strobes.stepDown = 1'b1;
            strobes.lastStep = edgePenult;
          end
        end
        SEG_LOW: begin
          if (cntQ == CNT_W'(loLast)) begin
            segD           = SEG_RISE;
            cntD           = '0;
            strobes.stepUp = 1'b1;
          end
        end
        default: begin
          if (edgeLast) begin
            segD            = SEG_HIGH;
            cntD            = '0;
            strobes.capture = 1'b1;
          end else begin
            strobes.stepUp   = 1'b1;
            strobes.lastStep = edgePenult;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      segQ   <= SEG_LOW;
      cntQ   <= '0;
      hiLenQ <= '0;
      loLenQ <= '0;
    end else begin
      segQ <= segD;
      cntQ <= cntD;
      if (strobes.idle || strobes.capture) begin
        hiLenQ <= highLen;
        loLenQ <= lowLen;
      end
    end
  end

  assign segState = segQ;

endmodule

// File: rtl/trap_datapath.sv
module trap_datapath
  import trap_pkg::*;
#(
  parameter int CODE_W     = 16,
  parameter int EDGE_STEPS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_strobes_t     strobes,
  input  logic [CODE_W-1:0] highLevel,
  input  logic [CODE_W-1:0] lowLevel,
  output logic [CODE_W-1:0] dacCode
);

  localparam int STEP_SHIFT = $clog2(EDGE_STEPS);

  logic [CODE_W-1:0]        latHigh, latLow, codeQ;
  logic signed [CODE_W:0]   stepQ, stepNew, span;
  logic [CODE_W-1:0]        upCode, downCode;

  assign span = $signed({1'b0, highLevel}) - $signed({1'b0, lowLevel});

  generate
    if ((1 << STEP_SHIFT) == EDGE_STEPS) begin : g_shift
      assign stepNew = span >>> STEP_SHIFT;
    end else begin : g_divide
      localparam logic signed [CODE_W:0] DIVISOR = EDGE_STEPS;
      assign stepNew = span / DIVISOR;
    end
  endgenerate

  assign upCode   = CODE_W'($signed({1'b0, codeQ}) + stepQ);
  assign downCode = CODE_W'($signed({1'b0, codeQ}) - stepQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      latHigh <= '0;
      latLow  <= '0;
      stepQ   <= '0;
      codeQ   <= '0;
    end else if (strobes.idle || strobes.capture) begin
      latHigh <= highLevel;
      latLow  <= lowLevel;
      stepQ   <= stepNew;
      codeQ   <= strobes.capture ? highLevel : lowLevel;
    end else if (strobes.stepDown) begin
      codeQ <= strobes.lastStep ? latLow : downCode;
    end else if (strobes.stepUp) begin
      codeQ <= strobes.lastStep ? latHigh : upCode;
    end
  end

  assign dacCode = codeQ;

endmodule

// File: rtl/trapezoid_sequencer.sv
module trapezoid_sequencer
  import trap_pkg::*;
#(
  parameter int CODE_W     = 16,
  parameter int LEN_W      = 16,
  parameter int EDGE_STEPS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [CODE_W-1:0] highLevel,
  input  logic [CODE_W-1:0] lowLevel,
  input  logic [LEN_W-1:0]  highLen,
  input  logic [LEN_W-1:0]  lowLen,
  output logic [CODE_W-1:0] dacCode,
  output logic [1:0]        segment
);

  ctrl_strobes_t strobes;
  segment_e      segState;

  trap_ctrl #(.LEN_W(LEN_W), .EDGE_STEPS(EDGE_STEPS)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .highLen  (highLen),
    .lowLen   (lowLen),
    .strobes  (strobes),
    .segState (segState)
  );

  trap_datapath #(.CODE_W(CODE_W), .EDGE_STEPS(EDGE_STEPS)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .highLevel (highLevel),
    .lowLevel  (lowLevel),
    .dacCode   (dacCode)
  );

  assign segment = segState;

endmodule

// File: rtl/trap_seq_chk.sv
module trap_seq_chk #(
  parameter int CODE_W     = 16,
  parameter int EDGE_STEPS = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              enable,
  input logic [CODE_W-1:0] lowLevel,
  input logic [CODE_W-1:0] dacCode,
  input logic [1:0]        segment
);

  logic [1:0] lastSeg;
  int         runLen;

  // length of the run of equal segment values seen at the previous sample
  always_ff @(posedge clk) begin
    if (rst) begin
      lastSeg <= 2'd2;
      runLen  <= 0;
    end else begin
      lastSeg <= segment;
      runLen  <= (segment == lastSeg) ? runLen + 1 : 1;
    end
  end

  // R2
  seg_order_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && segment != $past(segment)) |->
      (segment == 2'($past(segment) + 2'd1) || segment == 2'd2));

  // R7
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (segment == 2'd2 && dacCode == $past(lowLevel)));

  // R5
  plateau_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(enable) && segment == $past(segment) &&
     (segment == 2'd0 || segment == 2'd2)) |-> $stable(dacCode));

  // R2
  edge_len_chk: assert property (@(posedge clk) disable iff (rst)
    (lastSeg == 2'd1 || lastSeg == 2'd3) |-> runLen <= EDGE_STEPS);

  // R2
  edge_full_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(enable) &&
     ((lastSeg == 2'd1 && segment == 2'd2) || (lastSeg == 2'd3 && segment == 2'd0)))
      |-> runLen == EDGE_STEPS);

endmodule

bind trapezoid_sequencer trap_seq_chk #(.CODE_W(CODE_W), .EDGE_STEPS(EDGE_STEPS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .enable   (enable),
  .lowLevel (lowLevel),
  .dacCode  (dacCode),
  .segment  (segment)
);

// File: tb/sim_trapezoid_sequencer.sv
`timescale 1ns/1ps
module sim_trapezoid_sequencer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic [15:0] highLevel = '0, lowLevel = '0, highLen = '0, lowLen = '0;
  logic [15:0] dacCode;
  logic [1:0]  segment;
  int          nChecks = 0, nFail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  trapezoid_sequencer u0 (
    .clk(clk), .rst(rst), .enable(enable), .highLevel(highLevel), .lowLevel(lowLevel),
    .highLen(highLen), .lowLen(lowLen), .dacCode(dacCode), .segment(segment)
  );

  // {high, low, highLen, lowLen}
  localparam logic [63:0] VEC [6] = '{
    {16'hF000, 16'h1000, 16'd3, 16'd4},
    {16'h8000, 16'h7FF0, 16'd0, 16'd0},
    {16'h1234, 16'h0100, 16'd5, 16'd1},
    {16'hFFFF, 16'h0000, 16'd1, 16'd2},
    {16'h0500, 16'h0500, 16'd2, 16'd2},
    {16'h000F, 16'h0000, 16'd0, 16'd3}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [15:0] expCode, input logic [1:0] expSeg);
    nChecks++;
    if (dacCode !== expCode || segment !== expSeg) begin
      nFail++;
      $display("FAIL %s actual code=%h seg=%0d expected code=%h seg=%0d",
               tag, dacCode, segment, expCode, expSeg);
    end
  endtask

  task automatic waitSeg(input logic [1:0] target);
    for (int i = 0; i < 200 && segment !== target; i++) tick();
  endtask

  initial begin
    // R1: reset state
    lowLevel = 16'h0ABC;
    tick(); tick();
    check("R1", 16'h0000, 2'd2);
    rst = 1'b0;
    tick();
    check("R7", 16'h0ABC, 2'd2);

    // vector table: R2, R3, R4, R5, R8
    for (int v = 0; v < 6; v++) begin
      int hi, lo, lh, ll, per, st;
      enable    = 1'b0;
      highLevel = VEC[v][63:48];
      lowLevel  = VEC[v][47:32];
      highLen   = VEC[v][31:16];
      lowLen    = VEC[v][15:0];
      tick(); tick();
      hi  = int'(highLevel);
      lo  = int'(lowLevel);
      lh  = (highLen == 0) ? 1 : int'(highLen);
      ll  = (lowLen == 0) ? 1 : int'(lowLen);
      per = 32 + lh + ll;
      st  = (hi - lo) >>> 4;
      enable = 1'b1;
      for (int j = 0; j < ll - 1 + 2 * per; j++) begin
        int q;
        tick();
        if (j < ll - 1) begin
          check("R8", 16'(lo), 2'd2);
        end else begin
          q = (j - (ll - 1)) % per;
          if (q < 16)
            check((q == 15) ? "R4" : "R2", (q == 15) ? 16'(hi) : 16'(lo + (q + 1) * st), 2'd3);
          else if (q < 16 + lh)
            check((highLen == 0) ? "R3" : "R5", 16'(hi), 2'd0);
          else if (q < 32 + lh)
            check((q == 31 + lh) ? "R4" : "R2",
                  (q == 31 + lh) ? 16'(lo) : 16'(hi - (q - 15 - lh) * st), 2'd1);
          else
            check((lowLen == 0) ? "R3" : "R5", 16'(lo), 2'd2);
        end
      end
      enable = 1'b0;
      tick();
    end

    // R6: settings changed during a rising edge and during a falling edge
    highLevel = 16'hF000; lowLevel = 16'h1000; highLen = 16'd3; lowLen = 16'd4;
    tick(); tick();
    enable = 1'b1;
    waitSeg(2'd3);
    check("R6", 16'h1E00, 2'd3);
    highLevel = 16'h8000; lowLevel = 16'h0000; highLen = 16'd2; lowLen = 16'd1;
    repeat (15) tick();
    check("R6", 16'hF000, 2'd3);
    tick();
    check("R6", 16'h8000, 2'd0);
    tick();
    check("R6", 16'h8000, 2'd0);
    tick();
    check("R6", 16'h7800, 2'd1);
    highLevel = 16'h4000;
    repeat (15) tick();
    check("R6", 16'h0000, 2'd1);
    tick();
    check("R6", 16'h0000, 2'd2);
    tick();
    check("R6", 16'h0800, 2'd3);

    // R7: disable in the middle of a falling edge, then track the low input
    waitSeg(2'd1);
    tick();
    enable   = 1'b0;
    lowLevel = 16'h0ABC;
    tick();
    check("R7", 16'h0ABC, 2'd2);
    lowLevel = 16'h0DEF;
    tick();
    check("R7", 16'h0DEF, 2'd2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog R2 actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

endmodule